// File: doc/BRIEF.md
# Floating-Point Narrowing Converter

This block converts a binary floating-point value held in a wide format into a narrower interchange format, such as single precision into half precision. The exponent and fraction widths of both formats are parameters. The block takes the raw source bit pattern and returns the raw destination bit pattern. Only round-to-nearest with ties-to-even is supported.

Each input goes through one combinational datapath. That datapath sorts the value into one of four classes: in-range normal, not-a-number, overflow, or tiny. It then rounds the kept fraction bits, or it denormalizes the significand with a sticky right shift and then rounds. An optional register stage can follow the datapath. With that stage in place, a result and its valid flag appear one clock after the input was presented.

The design assumes that the source fraction is at least two bits wider than the destination fraction. It also assumes a destination fraction of at least two bits, that the source exponent is no narrower than the destination exponent, and that the source exponent bias is at least the destination bias.

Top module: `fpn_narrow`

## Requirements
- R1: While `rst_n` is low at a clock edge, the registered outputs clear: `out_valid` becomes 0 and `out_bits` becomes all zeros.
- R2: `out_valid` equals the `in_valid` of the previous cycle. `out_bits` is the conversion of the `in_bits` presented one cycle earlier.
- R3: The destination sign bit (MSB of `out_bits`) always equals the source sign bit (MSB of `in_bits`). This holds for zero, infinity and NaN results too.
- R4: If the rebiased exponent (source exponent − source bias + destination bias) lies between 1 and the all-ones exponent minus 1, the value is rounded as a normal number. The dropped low fraction bits are compared against the halfway pattern, which is a 1 in the top dropped position. An exact tie rounds up only when the kept LSB is 1.
- R5: When rounding carries out of the kept fraction, the exponent field increases by one and the fraction field becomes zero. The largest finite values that round up therefore become infinity.
- R6: A source exponent at or above the threshold (source bias + destination all-ones exponent − destination bias) gives a signed infinity: all-ones exponent and zero fraction. A source infinity also follows this rule.
- R7: A source NaN (all-ones exponent, nonzero fraction) gives the following result:
  - the exponent field is all ones;
  - the destination fraction MSB (quiet bit) is 1;
  - the lower destination fraction bits are the source fraction bits just below the source quiet bit, taken from the top down.
  
  No other input produces a NaN.
- R8: For a tiny normal source, the hidden one is inserted. The significand is then shifted right by (source bias − destination bias − exponent + 1), with any bits shifted out ORed into the LSB, and rounded to nearest-even. The result is a subnormal, or it is the smallest normal (exponent field 1, fraction 0) when rounding carries.
- R9: A tiny result whose shift exceeds the source fraction width is a signed zero. A source zero of either sign gives a zero of the same sign.
- R10: A subnormal source uses the shift (source bias − destination bias) with no hidden one. It then follows the same sticky-shift rounding as R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `in_bits` as carrying a value to convert |
| in_bits | input | 1+SRC_EXP+SRC_FRAC | Source pattern: sign, exponent, fraction from MSB down |
| out_valid | output | 1 | Marks `out_bits` as a converted result |
| out_bits | output | 1+DST_EXP+DST_FRAC | Destination pattern: sign, exponent, fraction from MSB down |

## Verification
The bench builds the converter with a 5-bit exponent and 6-bit fraction source and a 3-bit exponent and 2-bit fraction destination. This makes the source space only 4096 patterns, so every one of them is driven. A small destination pulls every case into the sweep: the overflow threshold, the carry into infinity, the subnormal-to-normal carry, the flush-to-zero limit and every NaN payload. Each result is compared with an exact scaled-integer model in the bench, and reset is applied both before and after the sweep.

// File: rtl/fpn_pkg.sv
// Shared types for the narrowing converter.
// Assumes nothing beyond IEEE-754 style field layout.
package fpn_pkg;

    // Class of a source value with respect to the destination range.
    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,  // rebiased exponent fits a destination normal
        CLS_NAN    = 2'd1,  // all-ones exponent, nonzero fraction
        CLS_INF    = 2'd2,  // at or above the overflow threshold
        CLS_TINY   = 2'd3   // below destination normal range, or zero
    } fpn_cls_e;

endpackage

// File: rtl/fpn_classify.sv
// Sorts a source exponent into a destination class.
// Also produces the rebiased exponent and the saturated denormalization shift.
// Assumes SRC_EXP >= DST_EXP, so the source bias is not below the destination bias.
module fpn_classify
    import fpn_pkg::*;
#(
    parameter int SRC_EXP  = 8,
    parameter int SRC_FRAC = 23,
    parameter int DST_EXP  = 5,
    parameter int SHW      = $clog2(SRC_FRAC + 2)
) (
    input  logic [SRC_EXP-1:0] exp_i,
    input  logic               frac_nz_i,
    output fpn_cls_e           cls_o,
    output logic [DST_EXP-1:0] nexp_o,
    output logic [SHW-1:0]     shamt_o,
    output logic               flush_o
);
    localparam int SMAX  = (1 << SRC_EXP) - 1;
    localparam int SBIAS = SMAX >> 1;
    localparam int DMAX  = (1 << DST_EXP) - 1;
    localparam int DBIAS = DMAX >> 1;
    localparam int OVF   = SBIAS + DMAX - DBIAS;

    int e_int;
    int cand;
    int shift;

    // Integer views of the exponent: rebiased candidate and shift amount.
    always_comb begin
        e_int = int'(exp_i);
        cand  = e_int - SBIAS + DBIAS;
        shift = SBIAS - DBIAS - e_int + ((exp_i != '0) ? 1 : 0);
    end

    // Class decision, in priority order NaN, in-range, overflow, tiny.
    always_comb begin
        if (e_int == SMAX && frac_nz_i) begin
            cls_o = CLS_NAN;
        end else if (cand >= 1 && cand <= DMAX - 1) begin
            cls_o = CLS_NORMAL;
        end else if (e_int >= OVF) begin
            cls_o = CLS_INF;
        end else begin
            cls_o = CLS_TINY;
        end
    end

    // Rebiased exponent and saturated shift for the tiny path.
    always_comb begin
        nexp_o  = DST_EXP'(cand);
        flush_o = (shift > SRC_FRAC);
        shamt_o = flush_o ? '0 : SHW'(shift);
    end

endmodule

// File: rtl/fpn_sticky_shr.sv
// Right shift that ORs every bit shifted out into the result LSB.
// Assumes the top input bit is always shifted out (shift >= 1) or is zero,
// so the output drops that position.
module fpn_sticky_shr #(
    parameter int W   = 24,
    parameter int SHW = 5
) (
    input  logic [W-1:0]   val_i,
    input  logic [SHW-1:0] sh_i,
    output logic [W-2:0]   val_o
);
    logic lost;

    // Collect discarded ones, then merge them as a sticky LSB.
    always_comb begin
        lost = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (i < int'(sh_i)) begin
                lost = lost | val_i[i];
            end
        end
        val_o = (W-1)'(val_i >> sh_i) | (W-1)'(lost);
    end

endmodule

// File: rtl/fpn_rne.sv
// Round-to-nearest, ties-to-even, on a kept field with a dropped field.
// The output is one bit wider to expose the carry out of the kept field.
// Assumes DW >= 1.
module fpn_rne #(
    parameter int KW = 10,
    parameter int DW = 13
) (
    input  logic [KW-1:0] keep_i,
    input  logic [DW-1:0] drop_i,
    output logic [KW:0]   sum_o
);
    localparam logic [DW-1:0] HALF = DW'(1) << (DW - 1);

    logic up;

    // Increment decision and sum.
    always_comb begin
        up    = (drop_i > HALF) | ((drop_i == HALF) & keep_i[0]);
        sum_o = {1'b0, keep_i} + {{KW{1'b0}}, up};
    end

endmodule

// File: rtl/fpn_narrow.sv
// Narrowing converter between two binary floating-point formats.
// Rounding is nearest-even only. The output register can be switched off
// with OUT_REG = 0.
// Assumes SRC_FRAC - DST_FRAC >= 2, DST_FRAC >= 2 and SRC_EXP >= DST_EXP.
module fpn_narrow
    import fpn_pkg::*;
#(
    parameter int SRC_EXP  = 8,
    parameter int SRC_FRAC = 23,
    parameter int DST_EXP  = 5,
    parameter int DST_FRAC = 10,
    parameter int OUT_REG  = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [SRC_EXP+SRC_FRAC:0]     in_bits,
    output logic                          out_valid,
    output logic [DST_EXP+DST_FRAC:0]     out_bits
);
    localparam int SW  = 1 + SRC_EXP + SRC_FRAC;
    localparam int DW  = 1 + DST_EXP + DST_FRAC;
    localparam int TW  = SRC_FRAC - DST_FRAC;
    localparam int SHW = $clog2(SRC_FRAC + 2);

    logic                 s_sign;
    logic [SRC_EXP-1:0]   s_exp;
    logic [SRC_FRAC-1:0]  s_frac;

    fpn_cls_e             cls;
    logic [DST_EXP-1:0]   nexp;
    logic [SHW-1:0]       shamt;
    logic                 flush;

    logic [DST_FRAC:0]    nrm_sum;
    logic [SRC_FRAC:0]    sig_full;
    logic [SRC_FRAC-1:0]  den;
    logic [DST_FRAC:0]    tny_sum;

    logic [DST_EXP-1:0]   r_exp;
    logic [DST_FRAC-1:0]  r_frac;
    logic [DW-1:0]        result;

    // Split the source pattern into its fields.
    always_comb begin
        s_sign = in_bits[SW-1];
        s_exp  = in_bits[SW-2 -: SRC_EXP];
        s_frac = in_bits[SRC_FRAC-1:0];
    end

    fpn_classify #(
        .SRC_EXP (SRC_EXP),
        .SRC_FRAC(SRC_FRAC),
        .DST_EXP (DST_EXP),
        .SHW     (SHW)
    ) u_cls (
        .exp_i    (s_exp),
        .frac_nz_i(|s_frac),
        .cls_o    (cls),
        .nexp_o   (nexp),
        .shamt_o  (shamt),
        .flush_o  (flush)
    );

    // In-range path: round the source fraction directly.
    fpn_rne #(
        .KW(DST_FRAC),
        .DW(TW)
    ) u_rne_nrm (
        .keep_i(s_frac[SRC_FRAC-1 -: DST_FRAC]),
        .drop_i(s_frac[TW-1:0]),
        .sum_o (nrm_sum)
    );

    // Tiny path: significand with hidden one for normals, none for subnormals.
    always_comb begin
        sig_full = {(s_exp != '0), s_frac};
    end

    fpn_sticky_shr #(
        .W  (SRC_FRAC + 1),
        .SHW(SHW)
    ) u_shr (
        .val_i(sig_full),
        .sh_i (shamt),
        .val_o(den)
    );

    fpn_rne #(
        .KW(DST_FRAC),
        .DW(TW)
    ) u_rne_tny (
        .keep_i(den[SRC_FRAC-1 -: DST_FRAC]),
        .drop_i(den[TW-1:0]),
        .sum_o (tny_sum)
    );

    // Pick the exponent and fraction for the decided class.
    always_comb begin
        unique case (cls)
            CLS_NORMAL: begin
                r_exp  = nexp + DST_EXP'(nrm_sum[DST_FRAC]);
                r_frac = nrm_sum[DST_FRAC-1:0];
            end
            CLS_NAN: begin
                r_exp  = '1;
                r_frac = {1'b1, s_frac[SRC_FRAC-2 -: DST_FRAC-1]};
            end
            CLS_INF: begin
                r_exp  = '1;
                r_frac = '0;
            end
            default: begin
                if (flush) begin
                    r_exp  = '0;
                    r_frac = '0;
                end else begin
                    r_exp  = DST_EXP'(tny_sum[DST_FRAC]);
                    r_frac = tny_sum[DST_FRAC-1:0];
                end
            end
        endcase
        result = {s_sign, r_exp, r_frac};
    end

    generate
        if (OUT_REG != 0) begin : g_reg
            // Output register with synchronous active-low clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    out_bits  <= '0;
                end else begin
                    out_valid <= in_valid;
                    out_bits  <= result;
                end
            end
        end else begin : g_comb
            // Pass-through when no register stage is wanted.
            always_comb begin
                out_valid = in_valid;
                out_bits  = result;
            end
        end
    endgenerate

endmodule

// File: rtl/fpn_narrow_chk.sv
// Property checker for fpn_narrow, bound to every instance.
// Checks only apply when the output register is present.
module fpn_narrow_chk #(
    parameter int SRC_EXP  = 8,
    parameter int SRC_FRAC = 23,
    parameter int DST_EXP  = 5,
    parameter int DST_FRAC = 10,
    parameter int OUT_REG  = 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [SRC_EXP+SRC_FRAC:0] in_bits,
    input logic                      out_valid,
    input logic [DST_EXP+DST_FRAC:0] out_bits
);
    localparam int SW = 1 + SRC_EXP + SRC_FRAC;
    localparam int DW = 1 + DST_EXP + DST_FRAC;

    logic in_eones, in_fnz, in_nan, in_inf, in_zero;
    logic out_eones, out_nan;

    assign in_eones  = &in_bits[SW-2 -: SRC_EXP];
    assign in_fnz    = |in_bits[SRC_FRAC-1:0];
    assign in_nan    = in_eones & in_fnz;
    assign in_inf    = in_eones & ~in_fnz;
    assign in_zero   = (in_bits[SW-2:0] == '0);
    assign out_eones = &out_bits[DW-2 -: DST_EXP];
    assign out_nan   = out_eones & (|out_bits[DST_FRAC-1:0]);

    generate
        if (OUT_REG != 0) begin : g_chk
            // R1
            reset_clear_chk: assert property (@(posedge clk)
                !rst_n |=> (!out_valid && out_bits == '0));
            // R2
            valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            // R2
            valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            // R3
            sign_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (out_bits[DW-1] == $past(in_bits[SW-1])));
            // R7
            nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_nan |=> (out_eones && out_bits[DST_FRAC-1]));
            // R7
            no_false_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_nan |=> !out_nan);
            // R6
            inf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_inf |=> (out_eones && out_bits[DST_FRAC-1:0] == '0));
            // R9
            zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_zero |=> (out_bits[DW-2:0] == '0));
        end
    endgenerate

endmodule

bind fpn_narrow fpn_narrow_chk #(
    .SRC_EXP (SRC_EXP),
    .SRC_FRAC(SRC_FRAC),
    .DST_EXP (DST_EXP),
    .DST_FRAC(DST_FRAC),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bits  (in_bits),
    .out_valid(out_valid),
    .out_bits (out_bits)
);

// File: tb/sim_fpn_narrow.sv
// Exhaustive sweep of a small converter configuration against an exact
// scaled-integer model computed in the bench.
module sim_fpn_narrow;
    localparam int CLK_PERIOD = 10;
    localparam int SE = 5;
    localparam int SF = 6;
    localparam int DE = 3;
    localparam int DF = 2;
    localparam int SW = 1 + SE + SF;
    localparam int DW = 1 + DE + DF;
    localparam int SMAX  = (1 << SE) - 1;
    localparam int SBIAS = SMAX >> 1;
    localparam int DMAX  = (1 << DE) - 1;
    localparam int DBIAS = DMAX >> 1;
    localparam int SC    = SBIAS + SF - 1;   // scale: value * 2^SC is an integer
    localparam int OVF   = SBIAS + DMAX - DBIAS;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [SW-1:0] in_bits;
    logic          out_valid;
    logic [DW-1:0] out_bits;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpn_narrow #(
        .SRC_EXP (SE),
        .SRC_FRAC(SF),
        .DST_EXP (DE),
        .DST_FRAC(DF),
        .OUT_REG (1)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_bits  (in_bits),
        .out_valid(out_valid),
        .out_bits (out_bits)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s in=%h actual=%h expected=%h", req, in_bits, act, expv);
        end
    endtask

    // Exact rounding of the source value onto the destination grid.
    function automatic logic [DW-1:0] ref_conv(input logic [SW-1:0] a);
        logic   sg;
        int     e, f, p, de, qs, be;
        longint v, n, rem, half;
        sg = a[SW-1];
        e  = int'(a[SW-2 -: SE]);
        f  = int'(a[SF-1:0]);
        if (e == SMAX) begin
            if (f != 0)
                return {sg, DE'(DMAX), 1'b1,
                        (DF-1)'((f & ((1 << (SF-1)) - 1)) >> (SF - DF))};
            return {sg, DE'(DMAX), DF'(0)};
        end
        v = longint'((e == 0) ? f : f + (1 << SF)) << (((e == 0) ? 1 : e) - 1);
        if (v == 0) return {sg, (DW-1)'(0)};
        p = 0;
        for (int b = 0; b < 63; b++) if (v[b]) p = b;
        de = p - SC;
        if (de < 1 - DBIAS) de = 1 - DBIAS;
        qs   = de - DF + SC;
        n    = v >> qs;
        rem  = v & ((longint'(1) << qs) - 1);
        half = longint'(1) << (qs - 1);
        if (rem > half || (rem == half && n[0])) n++;
        if (n == (longint'(1) << (DF + 1))) begin
            n = n >> 1;
            de++;
        end
        be = (n >= (longint'(1) << DF)) ? de + DBIAS : 0;
        if (be >= DMAX) return {sg, DE'(DMAX), DF'(0)};
        return {sg, DE'(be), DF'(n)};
    endfunction

    // Requirement tag for the behaviour a given pattern exercises.
    function automatic string tag_of(input logic [SW-1:0] a, input logic [DW-1:0] r);
        int e, f, cand, re;
        e    = int'(a[SW-2 -: SE]);
        f    = int'(a[SF-1:0]);
        cand = e - SBIAS + DBIAS;
        re   = int'(r[DW-2 -: DE]);
        if (e == SMAX && f != 0) return "R7";
        if (e == SMAX) return "R6";
        if (e == 0 && f == 0) return "R9";
        if (e == 0) return "R10";
        if (e >= OVF) return "R6";
        if (cand >= 1 && cand <= DMAX - 1) return (re != cand) ? "R5" : "R4";
        if (r[DW-2:0] == '0) return "R9";
        return "R8";
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] expv;
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_bits  = '1;
        repeat (3) @(negedge clk);
        // R1: outputs held clear in reset
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(out_bits == '0, "R1", int'(out_bits), 0);
        rst_n = 1'b1;

        for (int i = 0; i < (1 << SW); i++) begin
            in_valid = 1'b1;
            in_bits  = SW'(i);
            @(negedge clk);
            expv = ref_conv(in_bits);
            chk(out_valid == 1'b1, "R2", int'(out_valid), 1);
            chk(out_bits == expv, tag_of(in_bits, expv), int'(out_bits), int'(expv));
            chk(out_bits[DW-1] == in_bits[SW-1], "R3", int'(out_bits[DW-1]),
                int'(in_bits[SW-1]));
        end

        // R2: valid drops one cycle after input valid drops
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R2", int'(out_valid), 0);

        // R1: reset after traffic clears a nonzero output
        in_valid = 1'b1;
        in_bits  = {1'b1, SE'(SBIAS), SF'(0)};
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(out_bits == '0, "R1", int'(out_bits), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule